// File: doc/BRIEF.md
# Clock Power-Down Sequencer

This block sits between the control logic of a multi-output clock generator and its output gates. It takes an asynchronous, active-low power-down request and brings it into the CPU clock domain through two flip-flops. On a request, it first gates every clock output to a held low level without glitches. Only after every gate reports that it is closed does it drop the enables of the crystal oscillator and the VCO. When the request goes away, it turns the oscillator and VCO back on and waits a settling time set at a port. It then reopens the gates and reports stable clocks.

Each output group has its own stop request while the block runs. CPU outputs follow a CPU-stop input. All PCI outputs except bit 0 follow a PCI-stop input. PCI bit 0 and the fixed-frequency outputs run freely. A power-down request overrides both stop inputs. Each gate opens and closes on the falling edge of its own source clock, so that no runt pulse reaches an output. A spread-spectrum enable is taken from an active-low strap while reset is held and is kept from then on.

Top module: `clkpd_seq`

## Requirements
- R1: After pd_req_n goes low between clock edges, cpu_clk_o is still running in the high phase after the second rising edge of clk. It is held low from the following falling edge, and is low in the high phase after the third rising edge.
- R2: osc_en and vco_en go low only while every gated output is closed, and remain low with all outputs held low. pd_done is 1 exactly while they are low.
- R3: While power-down is in effect, changes on cpu_stop_n and pci_stop_n make no output toggle and do not raise osc_en.
- R4: In normal running, cpu_stop_n=0 holds all of cpu_clk_o low. pci_stop_n=0 holds pci_clk_o[NPCI-1:1] low. pci_clk_o[0] and all of fix_clk_o keep toggling whatever the stop inputs are.
- R5: After pd_req_n goes high between edges, osc_en and vco_en rise at the third rising edge of clk. Counting that edge as 0, cpu_clk_o first goes high in the high phase after rising edge number wake_cycles+2. Outputs stay closed until then.
- R6: clk_stable is 0 from the start of power-down until the end of wake-up. It rises only once pci_clk_o[0] and all fix_clk_o gates are open again.
- R7: ss_en equals the inverse of spread_strap_n as sampled while rst is high. Later changes of the strap have no effect.
- R8: After reset, osc_en=1, vco_en=1 and pd_done=0. clk_stable rises within a few cycles and all outputs run.
- R9: A power-down request that arrives during the wake-up settle returns the block to the powered-down state (osc_en=0). No output toggles on the way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal CPU clock; control clock and CPU output source |
| rst | input | 1 | Synchronous active-high reset |
| pd_req_n | input | 1 | Asynchronous power-down request, active low |
| cpu_stop_n | input | 1 | CPU group stop request, active low |
| pci_stop_n | input | 1 | PCI group stop request, active low (bit 0 exempt) |
| spread_strap_n | input | 1 | Spread-spectrum strap, active low, sampled during reset |
| wake_cycles | input | WCW | Settling count after oscillator restart |
| pci_src | input | 1 | Source clock of the PCI group |
| fix_src | input | 1 | Source clock of the fixed-frequency group |
| cpu_clk_o | output | NCPU | Gated CPU clocks |
| pci_clk_o | output | NPCI | Gated PCI clocks, bit 0 free-running |
| fix_clk_o | output | NFIX | Gated fixed-frequency clocks |
| osc_en | output | 1 | Crystal oscillator enable |
| vco_en | output | 1 | VCO enable |
| pd_done | output | 1 | Fully powered down |
| clk_stable | output | 1 | Clocks running and stable |
| ss_en | output | 1 | Latched spread-spectrum enable |

## Verification
The bench builds the block with the default sizes: two CPU outputs, six PCI outputs and two fixed outputs. The status synchronizer therefore collects ten gates from three clock domains with unrelated periods, so the phase relation between gate closure and the control clock varies from one power-down to the next. wake_cycles is driven over 0 to 23. This covers both the zero-length settle and longer windows, where a late power-down request can land inside the settle.

// File: rtl/clkpd_pkg.sv
package clkpd_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_GATE,
        ST_OSC_OFF,
        ST_WAKE,
        ST_UNGATE
    } pd_state_e;

    typedef struct packed {
        logic cpu;
        logic pci;
        logic free;
    } gate_req_t;

    typedef struct packed {
        logic osc;
        logic vco;
        logic done;
        logic stable;
    } pwr_ctl_t;

    // Gate requests: open only in RUN/UNGATE and while no power-down is seen.
    function automatic gate_req_t gate_request(pd_state_e st, logic pd_act,
                                               logic cpu_run, logic pci_run);
        gate_req_t r;
        logic ok;
        ok     = ((st == ST_RUN) || (st == ST_UNGATE)) && !pd_act;
        r.cpu  = ok && cpu_run;
        r.pci  = ok && pci_run;
        r.free = ok;
        return r;
    endfunction

    function automatic pwr_ctl_t pwr_controls(pd_state_e st);
        pwr_ctl_t p;
        p.osc    = (st != ST_OSC_OFF);
        p.vco    = (st != ST_OSC_OFF);
        p.done   = (st == ST_OSC_OFF);
        p.stable = (st == ST_RUN);
        return p;
    endfunction

endpackage

// File: rtl/clkpd_sync.sv
module clkpd_sync #(
    parameter int W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/clkpd_gate.sv
module clkpd_gate (
    input  logic src,
    input  logic rst,
    input  logic en_req,
    output logic en_q,
    output logic clk_o
);
    // Enable changes only on the falling edge, i.e. while src is low.
    always_ff @(negedge src) begin
        if (rst) en_q <= 1'b0;
        else     en_q <= en_req;
    end

    assign clk_o = src & en_q;
endmodule

// File: rtl/clkpd_fsm.sv
module clkpd_fsm
    import clkpd_pkg::*;
#(
    parameter int WCW = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           pd_act,
    input  logic           cpu_run,
    input  logic           pci_run,
    input  logic           all_off,
    input  logic           free_on,
    input  logic [WCW-1:0] wake_cycles,
    output gate_req_t      req,
    output pwr_ctl_t       pwr
);
    pd_state_e      state;
    logic [WCW-1:0] settle_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_UNGATE;
            settle_cnt <= '0;
        end else begin
            unique case (state)
                ST_RUN: begin
                    if (pd_act) state <= ST_GATE;
                end
                ST_GATE: begin
                    if (all_off) state <= ST_OSC_OFF;
                end
                ST_OSC_OFF: begin
                    settle_cnt <= '0;
                    if (!pd_act) state <= ST_WAKE;
                end
                ST_WAKE: begin
                    if (pd_act)                         state <= ST_GATE;
                    else if (settle_cnt == wake_cycles) state <= ST_UNGATE;
                    else                                settle_cnt <= settle_cnt + 1'b1;
                end
                ST_UNGATE: begin
                    if (pd_act)       state <= ST_GATE;
                    else if (free_on) state <= ST_RUN;
                end
                default: state <= ST_GATE;
            endcase
        end
    end

    always_comb begin
        req = gate_request(state, pd_act, cpu_run, pci_run);
        pwr = pwr_controls(state);
    end
endmodule

// File: rtl/clkpd_seq.sv
module clkpd_seq
    import clkpd_pkg::*;
#(
    parameter int NCPU = 2,
    parameter int NPCI = 6,
    parameter int NFIX = 2,
    parameter int WCW  = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pd_req_n,
    input  logic            cpu_stop_n,
    input  logic            pci_stop_n,
    input  logic            spread_strap_n,
    input  logic [WCW-1:0]  wake_cycles,
    input  logic            pci_src,
    input  logic            fix_src,
    output logic [NCPU-1:0] cpu_clk_o,
    output logic [NPCI-1:0] pci_clk_o,
    output logic [NFIX-1:0] fix_clk_o,
    output logic            osc_en,
    output logic            vco_en,
    output logic            pd_done,
    output logic            clk_stable,
    output logic            ss_en
);
    localparam int NG = NCPU + NPCI + NFIX;
    localparam logic [NG-1:0] FREE_MASK =
        ({NG{1'b1}} << (NCPU + NPCI)) | (NG'(1) << NCPU);

    logic [2:0]      in_s;
    logic [NCPU-1:0] cpu_on;
    logic [NPCI-1:0] pci_on;
    logic [NFIX-1:0] fix_on;
    logic [NG-1:0]   gate_on;
    logic [NG-1:0]   gate_on_s;
    logic            all_off;
    logic            free_on;
    gate_req_t       req;
    pwr_ctl_t        pwr;

    clkpd_sync #(.W(3), .RST_VAL(3'b111)) u_in_sync (
        .clk (clk),
        .rst (rst),
        .d   ({pd_req_n, cpu_stop_n, pci_stop_n}),
        .q   (in_s)
    );

    assign gate_on = {fix_on, pci_on, cpu_on};

    clkpd_sync #(.W(NG), .RST_VAL('0)) u_stat_sync (
        .clk (clk),
        .rst (rst),
        .d   (gate_on),
        .q   (gate_on_s)
    );

    assign all_off = (gate_on_s == '0);
    assign free_on = &(gate_on_s | ~FREE_MASK);

    clkpd_fsm #(.WCW(WCW)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .pd_act      (~in_s[2]),
        .cpu_run     (in_s[1]),
        .pci_run     (in_s[0]),
        .all_off     (all_off),
        .free_on     (free_on),
        .wake_cycles (wake_cycles),
        .req         (req),
        .pwr         (pwr)
    );

    for (genvar g = 0; g < NCPU; g++) begin : g_cpu
        clkpd_gate u_gate (
            .src (clk), .rst (rst), .en_req (req.cpu),
            .en_q (cpu_on[g]), .clk_o (cpu_clk_o[g])
        );
    end

    for (genvar g = 0; g < NPCI; g++) begin : g_pci
        if (g == 0) begin : g_free
            clkpd_gate u_gate (
                .src (pci_src), .rst (rst), .en_req (req.free),
                .en_q (pci_on[g]), .clk_o (pci_clk_o[g])
            );
        end else begin : g_stop
            clkpd_gate u_gate (
                .src (pci_src), .rst (rst), .en_req (req.pci),
                .en_q (pci_on[g]), .clk_o (pci_clk_o[g])
            );
        end
    end

    for (genvar g = 0; g < NFIX; g++) begin : g_fix
        clkpd_gate u_gate (
            .src (fix_src), .rst (rst), .en_req (req.free),
            .en_q (fix_on[g]), .clk_o (fix_clk_o[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) ss_en <= ~spread_strap_n;
    end

    assign osc_en     = pwr.osc;
    assign vco_en     = pwr.vco;
    assign pd_done    = pwr.done;
    assign clk_stable = pwr.stable;
endmodule

// File: rtl/clkpd_seq_chk.sv
module clkpd_seq_chk #(
    parameter int NCPU = 2,
    parameter int NPCI = 6,
    parameter int NFIX = 2
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      pd_req_n,
    input logic                      osc_en,
    input logic                      vco_en,
    input logic                      clk_stable,
    input logic                      ss_en,
    input logic [NCPU+NPCI+NFIX-1:0] gate_on
);
    localparam int NG = NCPU + NPCI + NFIX;
    localparam logic [NG-1:0] FREE_MASK =
        ({NG{1'b1}} << (NCPU + NPCI)) | (NG'(1) << NCPU);

    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                 since_rst <= '0;
        else if (since_rst != 3) since_rst <= since_rst + 1'b1;
    end

    AST_FAST_CPU_GATE: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 3 && !$past(pd_req_n, 2) && !$past(pd_req_n) && !pd_req_n)
        |-> (gate_on[NCPU-1:0] == '0)); // R1

    AST_OSC_OFF_CLOSED: assert property (@(posedge clk) disable iff (rst)
        (!osc_en || !vco_en) |-> (gate_on == '0)); // R2

    AST_WAKE_CLOSED: assert property (@(posedge clk) disable iff (rst)
        (since_rst != 0 && $rose(osc_en)) |-> (!clk_stable && gate_on == '0)); // R5

    AST_STABLE_FREE_OPEN: assert property (@(posedge clk) disable iff (rst)
        (since_rst != 0 && $rose(clk_stable)) |-> ((gate_on & FREE_MASK) == FREE_MASK)); // R6

    AST_STRAP_HELD: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2) |-> $stable(ss_en)); // R7
endmodule

bind clkpd_seq clkpd_seq_chk #(.NCPU(NCPU), .NPCI(NPCI), .NFIX(NFIX)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pd_req_n   (pd_req_n),
    .osc_en     (osc_en),
    .vco_en     (vco_en),
    .clk_stable (clk_stable),
    .ss_en      (ss_en),
    .gate_on    (gate_on)
);

// File: tb/test_clkpd_seq.sv
`timescale 1ns/100ps
module test_clkpd_seq;
    localparam int NCPU = 2;
    localparam int NPCI = 6;
    localparam int NFIX = 2;
    localparam int WCW  = 8;
    localparam int NG   = NCPU + NPCI + NFIX;

    logic clk = 0, rst = 1, pd_req_n = 1, cpu_stop_n = 1, pci_stop_n = 1;
    logic spread_strap_n = 0, pci_src = 0, fix_src = 0;
    logic [WCW-1:0]  wake_cycles = 3;
    logic [NCPU-1:0] cpu_clk_o;
    logic [NPCI-1:0] pci_clk_o;
    logic [NFIX-1:0] fix_clk_o;
    logic osc_en, vco_en, pd_done, clk_stable, ss_en;

    int total = 0, bad = 0, cyc = 0;

    always #5   clk = ~clk;
    always #15  pci_src = ~pci_src;
    always #7   fix_src = ~fix_src;

    clkpd_seq #(.NCPU(NCPU), .NPCI(NPCI), .NFIX(NFIX), .WCW(WCW)) i_clkpd_seq (
        .clk, .rst, .pd_req_n, .cpu_stop_n, .pci_stop_n, .spread_strap_n,
        .wake_cycles, .pci_src, .fix_src, .cpu_clk_o, .pci_clk_o, .fix_clk_o,
        .osc_en, .vco_en, .pd_done, .clk_stable, .ss_en
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++; bad++;
            $display("FAIL watchdog: run hung, actual=%0d expected<150000 cycles", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [NG-1:0] exp_running(input logic cs, input logic ps);
        logic [NG-1:0] v;
        v = '0;
        for (int i = 0; i < NCPU; i++) v[i] = cs;
        for (int i = 0; i < NPCI; i++) v[NCPU+i] = (i == 0) ? 1'b1 : ps;
        for (int i = 0; i < NFIX; i++) v[NCPU+NPCI+i] = 1'b1;
        return v;
    endfunction

    task automatic watch(input int ns, output logic [NG-1:0] seen);
        seen = '0;
        for (int t = 0; t < ns; t++) begin
            #1 seen |= {fix_clk_o, pci_clk_o, cpu_clk_o};
        end
    endtask

    task automatic run_mode(input logic cs, input logic ps);
        logic [NG-1:0] seen;
        @(negedge clk); cpu_stop_n = cs; pci_stop_n = ps;
        repeat (8) @(negedge clk);
        watch(100, seen);
        chk(seen == exp_running(cs, ps), "R4 stop pattern", seen, exp_running(cs, ps));
    endtask

    task automatic pd_enter();
        int n;
        logic zero_ok;
        @(negedge clk); cpu_stop_n = 1; pci_stop_n = 1;
        repeat (6) @(negedge clk);
        pd_req_n = 0;
        @(posedge clk); @(posedge clk); #1;
        chk(cpu_clk_o == '1, "R1 cpu running before cutoff", cpu_clk_o, {NCPU{1'b1}});
        @(posedge clk); #1;
        chk(cpu_clk_o == '0, "R1 cpu low by third edge", cpu_clk_o, 0);
        chk(clk_stable == 0, "R6 stable dropped", clk_stable, 0);
        n = 0; zero_ok = 1;
        while (!pd_done && n < 40) begin
            @(posedge clk); #1; n++;
        end
        for (int i = 0; i < 20; i++) begin
            #1 if ({fix_clk_o, pci_clk_o, cpu_clk_o} != '0 || osc_en) zero_ok = 0;
        end
        chk(pd_done == 1, "R2 pd_done reached", pd_done, 1);
        chk(osc_en == 0 && vco_en == 0, "R2 enables low", {osc_en, vco_en}, 0);
        chk(zero_ok, "R2 outputs held low with oscillator off", zero_ok, 1);
    endtask

    task automatic pd_stops();
        logic [NG-1:0] seen, acc;
        acc = '0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            cpu_stop_n = 1'($urandom); pci_stop_n = 1'($urandom);
            watch(30, seen); acc |= seen;
        end
        chk(acc == '0, "R3 stops ignored in power-down", acc, 0);
        chk(osc_en == 0 && pd_done == 1, "R3 still powered down", {osc_en, pd_done}, 1);
        @(negedge clk); cpu_stop_n = 1; pci_stop_n = 1;
        repeat (4) @(negedge clk);
    endtask

    task automatic pd_wake(input int w);
        int n;
        logic early;
        wake_cycles = WCW'(w);
        @(negedge clk); pd_req_n = 1;
        n = 0;
        while (!osc_en && n < 10) begin
            @(posedge clk); #1; n++;
        end
        chk(n == 3, "R5 oscillator restart edge", n, 3);
        chk(vco_en == 1, "R5 vco restarted", vco_en, 1);
        n = 0; early = 0;
        while (cpu_clk_o == '0 && n < 100) begin
            @(posedge clk); #1; n++;
            if (clk_stable) early = 1;
        end
        chk(n == w + 2, "R5 settle length", n, w + 2);
        chk(!early, "R6 not stable during settle", early, 0);
        n = 0;
        while (!clk_stable && n < 30) begin
            @(posedge clk); #1; n++;
        end
        chk(clk_stable == 1 && pd_done == 0, "R6 stable after wake", {clk_stable, pd_done}, 2);
    endtask

    initial begin
        logic [NG-1:0] seen;
        int n;
        logic zero_ok;
        void'($urandom(32'd7317));
        repeat (5) @(posedge clk);
        @(negedge clk); rst = 0;
        #2 spread_strap_n = 1;
        n = 0;
        while (!clk_stable && n < 30) begin
            @(posedge clk); #1; n++;
        end
        chk(osc_en && vco_en && !pd_done && clk_stable, "R8 reset state",
            {osc_en, vco_en, pd_done, clk_stable}, 4'b1101);
        chk(ss_en == 1, "R7 strap latched", ss_en, 1);
        watch(100, seen);
        chk(seen == '1, "R8 all outputs running", seen, {NG{1'b1}});

        run_mode(0, 1); run_mode(1, 0); run_mode(0, 0); run_mode(1, 1);

        pd_enter(); pd_stops(); pd_wake(0);
        pd_enter(); pd_stops(); pd_wake(7);
        for (int it = 0; it < 6; it++) begin
            run_mode(1'($urandom), 1'($urandom));
            pd_enter(); pd_stops(); pd_wake(int'($urandom % 24));
        end

        // R9: power-down during settle
        pd_enter();
        wake_cycles = 20;
        @(negedge clk); pd_req_n = 1;
        n = 0;
        while (!osc_en && n < 10) begin @(posedge clk); #1; n++; end
        repeat (4) @(negedge clk);
        pd_req_n = 0;
        n = 0; zero_ok = 1;
        while (osc_en && n < 60) begin
            #1 if ({fix_clk_o, pci_clk_o, cpu_clk_o} != '0) zero_ok = 0;
            n++;
        end
        chk(osc_en == 0 && pd_done == 1, "R9 back to powered down", {osc_en, pd_done}, 1);
        chk(zero_ok, "R9 no output toggled", zero_ok, 1);
        pd_wake(2);

        spread_strap_n = 0;
        repeat (5) @(negedge clk);
        chk(ss_en == 1, "R7 strap change ignored", ss_en, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule